// File: doc/BRIEF.md
# Downward-Growing Register Stack

This block is a last-in-first-out store built on a small internal register array. A top pointer always addresses the entry currently on top. The array fills from its highest index toward index zero. A push moves the pointer down by one and then writes the input word at the new address. A pop reads the word under the pointer into an output register and then moves the pointer up by one.

Two status flags follow the pointer. One flag reports a full stack, which happens when the pointer reaches zero. The other reports an empty stack, which happens when the pointer climbs back to its idle value, equal to the depth. The logic around the block raises a single-cycle push or pop strobe. A push onto a full stack and a pop from an empty stack do not touch the stored state; each raises a one-cycle error pulse. Strobing push and pop in the same cycle does nothing.

Top module: `lifo_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `err` is 0 and `dout` is 0.
- R2: A push on a stack that is not full stores `din`, and `empty` reads 0 from the next cycle onward.
- R3: After DEPTH accepted pushes, `full` reads 1. A further push is ignored: no entry changes, `full` stays 1, and `err` is 1 for exactly the following cycle.
- R4: A pop on a stack that is not empty places the top entry on `dout` in the cycle after the strobe. `dout` holds that value until the next accepted pop. Entries come out in reverse order of their pushes.
- R5: An accepted pop clears `full`. After as many pops as there were pushes, `empty` reads 1 again.
- R6: A pop on an empty stack is ignored: `dout` and the flags keep their values, and `err` is 1 for the following cycle.
- R7: When push and pop are strobed together, the stack contents, `dout` and both flags are unchanged, and `err` stays 0.
- R8: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| din | input | WIDTH | Word to push |
| dout | output | WIDTH | Word most recently popped |
| full | output | 1 | Stack holds DEPTH entries |
| empty | output | 1 | Stack holds no entries |
| err | output | 1 | One-cycle pulse after an ignored push or pop |

## Verification
Each result is registered, so it appears exactly one clock edge after the strobe. The flags, `dout` and `err` all change on the edge that captures a push or pop. The bench drives every strobe on a falling edge and reads the outputs at the next falling edge. This means each check samples the cycle in which the result is due. The check also confirms that `err` has fallen back to 0 one cycle later, which makes it a pulse and not a level.

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] TOP_IDLE = PW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    sp;

  wire           do_push = push & ~pop & ~full;
  wire           do_pop  = pop & ~push & ~empty;
  wire [PW-1:0]  sp_dn   = sp - 1'b1;
  wire [PW-1:0]  sp_up   = sp + 1'b1;
  wire [AW-1:0]  wr_idx  = sp_dn[AW-1:0];
  wire [AW-1:0]  rd_idx  = sp[AW-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= TOP_IDLE;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
      dout  <= '0;
    end else begin
      err <= (push & ~pop & full) | (pop & ~push & empty);
      if (do_push) begin
        sp    <= sp_dn;
        empty <= 1'b0;
        full  <= (sp_dn == '0);
      end else if (do_pop) begin
        dout  <= mem[rd_idx];
        sp    <= sp_up;
        full  <= 1'b0;
        empty <= (sp_up == TOP_IDLE);
      end
    end
  end
endmodule

module lifo_stack_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] dout,
  input logic             full,
  input logic             empty,
  input logic             err
);
  a_r2_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> !empty);

  a_r3_push_on_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (err && full && $stable(dout)));

  a_r5_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> !full);

  a_r6_pop_on_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (err && empty && $stable(dout)));

  a_r7_both_strobes_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (!err && $stable(dout) && $stable(full) && $stable(empty)));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind lifo_stack lifo_stack_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
  .dout(dout), .full(full), .empty(empty), .err(err)
);

// File: tb/lifo_stack_test.sv
module lifo_stack_test;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push = 1'b0;
  logic             pop = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             full, empty, err;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lifo_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(din),
    .dout(dout), .full(full), .empty(empty), .err(err)
  );

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic p, input logic q, input logic [WIDTH-1:0] d);
    push = p; pop = q; din = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "empty", WIDTH'(empty), 1);
    check("R1", "full", WIDTH'(full), 0);
    check("R1", "err", WIDTH'(err), 0);
    check("R1", "dout", dout, 0);
  endtask

  task automatic t_short_lifo();
    cycle(1, 0, 16'h1111);
    check("R2", "empty after push", WIDTH'(empty), 0);
    cycle(1, 0, 16'h2222);
    cycle(1, 0, 16'h3333);
    cycle(0, 0, 0);
    check("R4", "dout idle", dout, 0);
    cycle(0, 1, 0);
    check("R4", "pop 1", dout, 16'h3333);
    cycle(0, 0, 0);
    check("R4", "dout held", dout, 16'h3333);
    cycle(0, 1, 0);
    check("R4", "pop 2", dout, 16'h2222);
    check("R5", "not empty yet", WIDTH'(empty), 0);
    cycle(0, 1, 0);
    check("R4", "pop 3", dout, 16'h1111);
    check("R5", "empty again", WIDTH'(empty), 1);
  endtask

  task automatic t_fill_and_drain();
    for (int i = 0; i < DEPTH; i++) begin
      cycle(1, 0, WIDTH'(16'hA000 + i));
      check("R8", "flags", WIDTH'(full & empty), 0);
      if (i < DEPTH - 1) check("R3", "full early", WIDTH'(full), 0);
    end
    check("R3", "full", WIDTH'(full), 1);
    check("R3", "err before", WIDTH'(err), 0);
    cycle(1, 0, 16'hDEAD);
    check("R3", "err pulse", WIDTH'(err), 1);
    check("R3", "still full", WIDTH'(full), 1);
    cycle(0, 0, 0);
    check("R3", "err cleared", WIDTH'(err), 0);
    cycle(0, 1, 0);
    check("R3", "top unchanged", dout, WIDTH'(16'hA000 + DEPTH - 1));
    check("R5", "full cleared", WIDTH'(full), 0);
    for (int i = DEPTH - 2; i >= 0; i--) begin
      cycle(0, 1, 0);
      check("R4", "drain order", dout, WIDTH'(16'hA000 + i));
    end
    check("R5", "empty after drain", WIDTH'(empty), 1);
  endtask

  task automatic t_pop_empty();
    logic [WIDTH-1:0] held;
    held = dout;
    cycle(0, 1, 0);
    check("R6", "err pulse", WIDTH'(err), 1);
    check("R6", "dout kept", dout, held);
    check("R6", "still empty", WIDTH'(empty), 1);
    cycle(0, 0, 0);
    check("R6", "err cleared", WIDTH'(err), 0);
  endtask

  task automatic t_both();
    cycle(1, 0, 16'h5A5A);
    cycle(1, 1, 16'hFFFF);
    check("R7", "err", WIDTH'(err), 0);
    check("R7", "empty", WIDTH'(empty), 0);
    check("R7", "dout", dout, 16'hA000);
    cycle(1, 1, 16'hFFFF);
    cycle(0, 1, 0);
    check("R7", "top kept", dout, 16'h5A5A);
    check("R7", "empty after", WIDTH'(empty), 1);
    cycle(1, 1, 16'h7777);
    check("R7", "err on empty", WIDTH'(err), 0);
    check("R7", "still empty", WIDTH'(empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_lifo();
    t_fill_and_drain();
    t_pop_empty();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule